// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt request lines and two fast-interrupt lines and turns them into one normal interrupt request (`irq_o`) and one fast-interrupt request (`fiq_o`) for a processor. Each channel carries its own enable, a sticky pending flag, a 4-bit priority level and a 16-bit vector value. All of these sit behind a simple single-cycle register port. A combinational arbiter finds the highest-priority channel that is both pending and enabled. `irq_o` is raised only when that channel outranks the level currently being serviced.

Software acknowledges an interrupt by reading the vector register. That read returns the winner's vector, saves the current channel and level on a 16-entry nesting stack, makes the winner the current one and clears its pending flag. An end-of-service strobe pops the stack and restores the interrupted level, so a high-priority handler can preempt a low-priority one. The fast path has its own two-bit enable pattern and two write-one-to-clear pending flags. Both outputs are gated by separate global enables.

Register access is one cycle. On a read, `rdata_o` is combinational in the cycle where `req_i` is high and `we_i` is low. Writes and acknowledge side effects take effect at that cycle's rising clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every enable, pending flag, priority, vector, global enable, fast enable, current channel, current level and the stack depth are zero, and `irq_o` and `fiq_o` are low.
- R2: A channel's pending flag is set in any of three ways: while its `src_i` bit is high, by writing 1 to its bit in the pending register (offset 0x18; writing 0 has no effect), or by writing 1 to bit 5 of its source register. When a set and an acknowledge clear land in the same cycle, the set wins. The pending register reads back all 32 flags.
- R3: Channel n has a source register at offset 0x40+4n. It holds the priority in bits 3:0, the enable in bit 4, the pending flag in bit 5 (read-only view) and the vector in bits 31:16; other bits read 0. The enable register at offset 0x14 reads and writes all 32 enables, one bit per channel.
- R4: The winner is the pending, enabled channel with the largest nonzero priority. Ties go to the lower channel number. A channel at priority 0 never wins.
- R5: `irq_o` is high exactly when the global IRQ enable is set and a winner exists whose priority is strictly greater than the current level.
- R6: A read of offset 0x10 returns the winner's vector zero-extended, or 0 if there is no winner. If a winner exists, the stack is not full and `eoi_i` is low in that cycle, the read also does three things: it pushes the current channel and level, makes the winner current, and clears its pending flag. The winner is taken regardless of the current level.
- R7: Offset 0x04 reads the current channel and offset 0x08 reads the current level, both zero-extended and read-only.
- R8: A high `eoi_i` pulse with a non-empty stack pops it and restores the saved channel and level. With an empty stack it has no effect. An `eoi_i` in the same cycle as a vector read blocks that read's acknowledge.
- R9: With 16 entries on the stack, a vector read still returns the winner's vector but changes no state.
- R10: The fast register at offset 0x0C holds the fast enables in bits 1:0 and the fast pending flags in bits 3:2. A pending flag is set while its `fast_src_i` line is high and is cleared by writing 1 to it; the set wins over the clear. `fiq_o` is high exactly when the global FIQ enable is set, both fast enable bits are 1, and at least one fast pending flag is set.
- R11: The control register at offset 0x00 holds the global IRQ enable in bit 0 and the global FIQ enable in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read request |
| src_i | input | 32 | Interrupt request lines, one per channel |
| fast_src_i | input | 2 | Fast-interrupt request lines |
| eoi_i | input | 1 | End-of-service strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted stack entry or pointer appears at the ports as a wrong current channel or level after the next end-of-service pulse. It also changes `irq_o` in that same cycle, because the comparison against the restored level flips. A wrong pending flag or arbitration result shows in the next vector read and in `irq_o` one cycle after the bad update. The bench checks `irq_o` and `fiq_o` in every cycle and every read result against a reference model. It also forces a full stack, tied priorities, priority-zero channels and colliding set/clear events, so faults are caught within one or two cycles of the event that exposes them.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned OFS_CTRL     = 'h00;
  localparam int unsigned OFS_CUR_CH   = 'h04;
  localparam int unsigned OFS_CUR_PRI  = 'h08;
  localparam int unsigned OFS_FAST     = 'h0C;
  localparam int unsigned OFS_VEC      = 'h10;
  localparam int unsigned OFS_EN       = 'h14;
  localparam int unsigned OFS_PEND     = 'h18;
  localparam int unsigned OFS_SRC_BASE = 'h40;

  localparam int unsigned SRC_PRI_LSB  = 0;
  localparam int unsigned SRC_EN_BIT   = 4;
  localparam int unsigned SRC_PEND_BIT = 5;
  localparam int unsigned SRC_VEC_LSB  = 16;

  localparam int unsigned CTRL_IRQ_BIT = 0;
  localparam int unsigned CTRL_FIQ_BIT = 1;
  localparam int unsigned FAST_EN_LSB  = 0;
  localparam int unsigned FAST_PND_LSB = 2;
endpackage

// File: rtl/pic_chan_bank.sv
module pic_chan_bank
  import pic_pkg::*;
#(
  parameter int unsigned NCH   = 32,
  parameter int unsigned PRI_W = 4,
  parameter int unsigned VEC_W = 16,
  parameter int unsigned AW    = 8,
  localparam int unsigned IDW  = $clog2(NCH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NCH-1:0]             src_i,
  input  logic                       wr_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [31:0]                wdata_i,
  input  logic                       clr_i,
  input  logic [IDW-1:0]             clr_id_i,
  output logic [NCH-1:0]             en_o,
  output logic [NCH-1:0]             pend_o,
  output logic [NCH-1:0][PRI_W-1:0]  pri_o,
  output logic [NCH-1:0][VEC_W-1:0]  vec_o
);
  logic wr_en_reg, wr_pend_reg;
  assign wr_en_reg   = wr_i && (addr_i == AW'(OFS_EN));
  assign wr_pend_reg = wr_i && (addr_i == AW'(OFS_PEND));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] SRC_ADDR = AW'(OFS_SRC_BASE + 4 * g);
    logic sel_src, set_p, clr_p;

    assign sel_src = wr_i && (addr_i == SRC_ADDR);
    assign set_p   = src_i[g] || (sel_src && wdata_i[SRC_PEND_BIT]) ||
                     (wr_pend_reg && wdata_i[g]);
    assign clr_p   = clr_i && (clr_id_i == IDW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g]   <= 1'b0;
        pend_o[g] <= 1'b0;
        pri_o[g]  <= '0;
        vec_o[g]  <= '0;
      end else begin
        if (sel_src) begin
          en_o[g]  <= wdata_i[SRC_EN_BIT];
          pri_o[g] <= wdata_i[SRC_PRI_LSB +: PRI_W];
          vec_o[g] <= wdata_i[SRC_VEC_LSB +: VEC_W];
        end else if (wr_en_reg) begin
          en_o[g]  <= wdata_i[g];
        end
        // set dominates an acknowledge clear
        pend_o[g] <= set_p || (pend_o[g] && !clr_p);
      end
    end

    a_r2_src_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_i[g] |=> pend_o[g]);
    a_r6_clear_drops_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_p && !set_p) |=> !pend_o[g]);
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned NCH   = 32,
  parameter int unsigned PRI_W = 4,
  localparam int unsigned IDW  = $clog2(NCH)
) (
  input  logic [NCH-1:0]            req_i,
  input  logic [NCH-1:0][PRI_W-1:0] pri_i,
  output logic                      valid_o,
  output logic [IDW-1:0]            id_o,
  output logic [PRI_W-1:0]          pri_o
);
  // strict compare: equal priority keeps the lower channel, level 0 never wins
  always_comb begin
    pri_o = '0;
    id_o  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req_i[i] && (pri_i[i] > pri_o)) begin
        pri_o = pri_i[i];
        id_o  = IDW'(i);
      end
    end
  end
  assign valid_o = (pri_o != '0);

  always_comb begin
    if (valid_o) a_r4_winner_requests: assert (req_i[id_o] && pri_i[id_o] == pri_o);
  end
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 9,
  localparam int unsigned SPW  = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [SPW-1:0]          sp_q;

  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign top_o   = mem_q[IW'(sp_q - SPW'(1))];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (pop_i) begin
      sp_q <= sp_q - SPW'(1);
    end else if (push_i) begin
      sp_q <= sp_q + SPW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !pop_i) mem_q[IW'(sp_q)] <= push_data_i;
  end

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r8_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> sp_q == $past(sp_q) - SPW'(1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NCH   = 32,
  parameter int unsigned PRI_W = 4,
  parameter int unsigned VEC_W = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 8,
  localparam int unsigned IDW  = $clog2(NCH),
  localparam int unsigned SW   = IDW + PRI_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [NCH-1:0]  src_i,
  input  logic [1:0]      fast_src_i,
  input  logic            eoi_i,
  output logic            irq_o,
  output logic            fiq_o
);
  logic                      wr, rd, vec_rd;
  logic [NCH-1:0]            en_w, pend_w;
  logic [NCH-1:0][PRI_W-1:0] pri_w;
  logic [NCH-1:0][VEC_W-1:0] vec_w;
  logic                      win_valid;
  logic [IDW-1:0]            win_id;
  logic [PRI_W-1:0]          win_pri;
  logic                      ack, pop, st_full, st_empty;
  logic [SW-1:0]             st_top;
  logic                      irq_en_q, fiq_en_q;
  logic [1:0]                fast_en_q, fast_pend_q;
  logic [IDW-1:0]            cur_ch_q;
  logic [PRI_W-1:0]          cur_pri_q;

  assign wr     = req_i && we_i;
  assign rd     = req_i && !we_i;
  assign vec_rd = rd && (addr_i == AW'(OFS_VEC));
  assign ack    = vec_rd && win_valid && !st_full && !eoi_i;
  assign pop    = eoi_i && !st_empty;

  pic_chan_bank #(.NCH(NCH), .PRI_W(PRI_W), .VEC_W(VEC_W), .AW(AW)) u_bank (
    .clk_i, .rst_ni, .src_i,
    .wr_i(wr), .addr_i, .wdata_i,
    .clr_i(ack), .clr_id_i(win_id),
    .en_o(en_w), .pend_o(pend_w), .pri_o(pri_w), .vec_o(vec_w)
  );

  pic_arbiter #(.NCH(NCH), .PRI_W(PRI_W)) u_arb (
    .req_i(en_w & pend_w), .pri_i(pri_w),
    .valid_o(win_valid), .id_o(win_id), .pri_o(win_pri)
  );

  pic_stack #(.DEPTH(DEPTH), .W(SW)) u_stack (
    .clk_i, .rst_ni,
    .push_i(ack), .pop_i(pop),
    .push_data_i({cur_ch_q, cur_pri_q}),
    .top_o(st_top), .full_o(st_full), .empty_o(st_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_ch_q  <= '0;
      cur_pri_q <= '0;
    end else if (pop) begin
      {cur_ch_q, cur_pri_q} <= st_top;
    end else if (ack) begin
      cur_ch_q  <= win_id;
      cur_pri_q <= win_pri;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q    <= 1'b0;
      fiq_en_q    <= 1'b0;
      fast_en_q   <= '0;
      fast_pend_q <= '0;
    end else begin
      if (wr && addr_i == AW'(OFS_CTRL)) begin
        irq_en_q <= wdata_i[CTRL_IRQ_BIT];
        fiq_en_q <= wdata_i[CTRL_FIQ_BIT];
      end
      if (wr && addr_i == AW'(OFS_FAST)) begin
        fast_en_q   <= wdata_i[FAST_EN_LSB +: 2];
        fast_pend_q <= fast_src_i | (fast_pend_q & ~wdata_i[FAST_PND_LSB +: 2]);
      end else begin
        fast_pend_q <= fast_src_i | fast_pend_q;
      end
    end
  end

  assign irq_o = irq_en_q && win_valid && (win_pri > cur_pri_q);
  assign fiq_o = fiq_en_q && (&fast_en_q) && (|fast_pend_q);

  // read mux
  localparam int unsigned SRC_END = OFS_SRC_BASE + 4 * NCH;
  logic           src_hit;
  logic [IDW-1:0] src_idx;
  logic [31:0]    rmux;

  assign src_hit = (int'(addr_i) >= OFS_SRC_BASE) && (int'(addr_i) < SRC_END) &&
                   (addr_i[1:0] == 2'b00);
  assign src_idx = IDW'((addr_i - AW'(OFS_SRC_BASE)) >> 2);

  always_comb begin
    rmux = '0;
    if (src_hit) begin
      rmux[SRC_PRI_LSB +: PRI_W] = pri_w[src_idx];
      rmux[SRC_EN_BIT]           = en_w[src_idx];
      rmux[SRC_PEND_BIT]         = pend_w[src_idx];
      rmux[SRC_VEC_LSB +: VEC_W] = vec_w[src_idx];
    end else begin
      case (int'(addr_i))
        OFS_CTRL: begin
          rmux[CTRL_IRQ_BIT] = irq_en_q;
          rmux[CTRL_FIQ_BIT] = fiq_en_q;
        end
        OFS_CUR_CH:  rmux[IDW-1:0]   = cur_ch_q;
        OFS_CUR_PRI: rmux[PRI_W-1:0] = cur_pri_q;
        OFS_FAST: begin
          rmux[FAST_EN_LSB +: 2]  = fast_en_q;
          rmux[FAST_PND_LSB +: 2] = fast_pend_q;
        end
        OFS_VEC:  if (win_valid) rmux[VEC_W-1:0] = vec_w[win_id];
        OFS_EN:   rmux[NCH-1:0] = en_w;
        OFS_PEND: rmux[NCH-1:0] = pend_w;
        default:  rmux = '0;
      endcase
    end
  end
  assign rdata_o = rd ? rmux : '0;

  a_r6_ack_takes_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> (cur_ch_q == $past(win_id)) && (cur_pri_q == $past(win_pri)));
  a_r8_pop_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> {cur_ch_q, cur_pri_q} == $past(st_top));
  a_r9_full_holds_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && st_full && !eoi_i) |=> $stable(cur_ch_q) && $stable(cur_pri_q));
  a_r10_fast_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == AW'(OFS_FAST) && wdata_i[FAST_PND_LSB] && !fast_src_i[0])
      |=> !fast_pend_q[0]);
  a_r5_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> irq_en_q);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we, eoi;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata, src;
  logic [1:0]  fsrc;
  logic        irq, fiq;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .fast_src_i(fsrc),
    .eoi_i(eoi), .irq_o(irq), .fiq_o(fiq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit          m_en[32], m_pend[32];
  logic [3:0]  m_pri[32];
  logic [15:0] m_vec[32];
  bit          m_irq_en, m_fiq_en;
  logic [1:0]  m_fen, m_fpend;
  int          cur_ch, cur_pri, sp;
  int          st_ch[16], st_pri[16];

  function automatic int winner();
    int w = -1, bp = 0;
    for (int i = 0; i < 32; i++)
      if (m_en[i] && m_pend[i] && int'(m_pri[i]) > bp) begin bp = int'(m_pri[i]); w = i; end
    return w;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] r = '0;
    int w;
    if (a >= 8'h40 && a < 8'hC0 && a[1:0] == 2'b00) begin
      int n = int'((a - 8'h40) >> 2);
      r[3:0] = m_pri[n]; r[4] = m_en[n]; r[5] = m_pend[n]; r[31:16] = m_vec[n];
      return r;
    end
    case (a)
      8'h00: r = {30'd0, m_fiq_en, m_irq_en};
      8'h04: r = 32'(cur_ch);
      8'h08: r = 32'(cur_pri);
      8'h0C: r = {28'd0, m_fpend, m_fen};
      8'h10: begin w = winner(); if (w >= 0) r = {16'd0, m_vec[w]}; end
      8'h14: for (int i = 0; i < 32; i++) r[i] = m_en[i];
      8'h18: for (int i = 0; i < 32; i++) r[i] = m_pend[i];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    if (a >= 8'h40) return "R3";
    case (a)
      8'h00: return "R11";
      8'h04, 8'h08: return "R7";
      8'h0C: return "R10";
      8'h10: return "R6";
      8'h14: return "R3";
      8'h18: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit rq, bit w_e, logic [7:0] a, logic [31:0] d,
                            logic [31:0] s, logic [1:0] fs, bit e);
    int  w = winner();
    bit  ack = rq && !w_e && a == 8'h10 && w >= 0 && sp < 16 && !e;
    bit  pop = e && sp > 0;
    if (ack) m_pend[w] = 0;
    if (rq && w_e) begin
      if (a >= 8'h40 && a < 8'hC0 && a[1:0] == 2'b00) begin
        int n = int'((a - 8'h40) >> 2);
        m_pri[n] = d[3:0]; m_en[n] = d[4]; m_vec[n] = d[31:16];
        if (d[5]) m_pend[n] = 1;
      end else case (a)
        8'h00: begin m_irq_en = d[0]; m_fiq_en = d[1]; end
        8'h0C: begin m_fen = d[1:0]; m_fpend = m_fpend & ~d[3:2]; end
        8'h14: for (int i = 0; i < 32; i++) m_en[i] = d[i];
        8'h18: for (int i = 0; i < 32; i++) if (d[i]) m_pend[i] = 1;
        default: ;
      endcase
    end
    for (int i = 0; i < 32; i++) if (s[i]) m_pend[i] = 1;
    m_fpend = m_fpend | fs;
    if (pop) begin
      sp--; cur_ch = st_ch[sp]; cur_pri = st_pri[sp];
    end else if (ack) begin
      st_ch[sp] = cur_ch; st_pri[sp] = cur_pri; sp++;
      cur_ch = w; cur_pri = int'(m_pri[w]);
    end
  endtask

  // one bus cycle: drive at negedge, check combinational outputs, update model at posedge
  task automatic cyc(bit rq, bit w_e, logic [7:0] a, logic [31:0] d,
                     logic [31:0] s, logic [1:0] fs, bit e, string tag);
    int w;
    bit exp_irq, exp_fiq;
    @(negedge clk);
    req = rq; we = w_e; addr = a; wdata = d; src = s; fsrc = fs; eoi = e;
    #1;
    w = winner();
    exp_irq = m_irq_en && w >= 0 && int'(m_pri[w]) > cur_pri;
    exp_fiq = m_fiq_en && m_fen == 2'b11 && m_fpend != 2'b00;
    chk((tag == "") ? "R5" : tag, "irq_o", 32'(irq), 32'(exp_irq));
    chk((tag == "") ? "R10" : tag, "fiq_o", 32'(fiq), 32'(exp_fiq));
    if (rq && !w_e) chk((tag == "") ? rd_tag(a) : tag, "rdata_o", rdata, exp_rd(a));
    @(posedge clk);
    model_step(rq, w_e, a, d, s, fs, e);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d, string tag);
    cyc(1, 1, a, d, '0, '0, 0, tag);
  endtask
  task automatic rd_reg(logic [7:0] a, string tag);
    cyc(1, 0, a, '0, '0, '0, 0, tag);
  endtask
  task automatic src_cfg(int n, int pri, int en, int pend, logic [15:0] v, string tag);
    wr_reg(8'(8'h40 + 4 * n), {v, 10'd0, pend[0], en[0], 4'(pri)}, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    for (int i = 0; i < 32; i++) begin m_en[i] = 0; m_pend[i] = 0; m_pri[i] = 0; m_vec[i] = 0; end
    m_irq_en = 0; m_fiq_en = 0; m_fen = 0; m_fpend = 0; cur_ch = 0; cur_pri = 0; sp = 0;
    rst_n = 0; req = 0; we = 0; addr = 0; wdata = 0; src = 0; fsrc = 0; eoi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    foreach (addr_list[k]) rd_reg(addr_list[k], "R1");
    rd_reg(8'h40, "R1");
    rd_reg(8'hBC, "R1");

    // R11 / R5: global enable gates irq
    src_cfg(3, 5, 1, 1, 16'hA003, "R5");
    rd_reg(8'h00, "R11");
    wr_reg(8'h00, 32'h3, "R11");
    rd_reg(8'h00, "R11");

    // R4: tie goes to the lower channel, priority 0 never wins
    src_cfg(9, 9, 1, 1, 16'hB009, "R4");
    src_cfg(2, 9, 1, 1, 16'hB002, "R4");
    src_cfg(1, 0, 1, 1, 16'hB001, "R4");
    rd_reg(8'h10, "R4");
    rd_reg(8'h04, "R7");
    rd_reg(8'h08, "R7");
    rd_reg(8'h10, "R4");
    // R8: eoi together with a vector read blocks the acknowledge
    cyc(1, 0, 8'h10, '0, '0, '0, 1, "R8");
    rd_reg(8'h04, "R8");
    cyc(0, 0, 8'h00, '0, '0, '0, 1, "R8");
    cyc(0, 0, 8'h00, '0, '0, '0, 1, "R8");
    rd_reg(8'h08, "R8");
    // R2: source line high in the acknowledge cycle keeps the flag set
    cyc(1, 0, 8'h10, '0, 32'h1 << 3, '0, 0, "R2");
    rd_reg(8'h18, "R2");
    wr_reg(8'h18, 32'h0, "R2");
    rd_reg(8'h18, "R2");

    // R9: fill the stack with priority-1 channels
    wr_reg(8'h14, 32'h0, "R3");
    repeat (4) cyc(0, 0, 8'h00, '0, '0, '0, 1, "R8");
    for (int n = 0; n < 17; n++) src_cfg(n + 10 > 31 ? n - 5 : n + 10, 1, 1, 1, 16'(16'hC000 + n), "R9");
    for (int n = 0; n < 18; n++) rd_reg(8'h10, "R9");
    rd_reg(8'h04, "R9");
    rd_reg(8'h18, "R9");
    for (int n = 0; n < 18; n++) cyc(0, 0, 8'h00, '0, '0, '0, 1, "R8");
    rd_reg(8'h04, "R8");
    rd_reg(8'h08, "R8");

    // R10: fast path needs both enable bits, pending is write-one-to-clear
    cyc(0, 0, 8'h00, '0, '0, 2'b10, 0, "R10");
    wr_reg(8'h0C, 32'h1, "R10");
    wr_reg(8'h0C, 32'h3, "R10");
    rd_reg(8'h0C, "R10");
    cyc(1, 1, 8'h0C, 32'hB, '0, 2'b01, 0, "R10");
    rd_reg(8'h0C, "R10");
    wr_reg(8'h0C, 32'h7, "R10");
    rd_reg(8'h0C, "R10");

    // random traffic
    for (int it = 0; it < 4000; it++) begin
      int op = int'($urandom % 16);
      logic [31:0] s = ($urandom % 10 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      logic [1:0]  fs = ($urandom % 12 == 0) ? 2'($urandom) : 2'b00;
      bit e = ($urandom % 7 == 0);
      logic [31:0] d = $urandom;
      if (op < 4)       cyc(1, 1, 8'(8'h40 + 4 * ($urandom % 32)), d, s, fs, e, "");
      else if (op == 4) cyc(1, 1, 8'h14, d, s, fs, e, "");
      else if (op == 5) cyc(1, 1, 8'h18, d & $urandom & $urandom, s, fs, e, "");
      else if (op == 6) cyc(1, 1, 8'h00, {30'd0, 2'($urandom % 8 != 0 ? 3 : d[1:0])}, s, fs, e, "");
      else if (op == 7) cyc(1, 1, 8'h0C, d, s, fs, e, "");
      else if (op < 13) cyc(1, 0, 8'h10, '0, s, fs, e, "");
      else              cyc(1, 0, 8'(($urandom % 48) * 4), '0, s, fs, e, "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [7:0] addr_list [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20};
endmodule